// File: doc/BRIEF.md
# IR Receive Byte Buffer with Interrupt Flags

This block sits behind an infrared pulse encoder. The encoder hands it one run-length byte per valid strobe, plus a single-cycle pulse when a packet ends. The block keeps the bytes in a 16-entry first-in first-out buffer. Software drains the buffer through a small register port. Each read of the data address returns the oldest byte and removes it.

Three sticky event flags drive one interrupt line: buffer overflow, packet end, and buffer fill above a programmable level. Each flag has its own enable bit. Software clears a flag by writing one to its status bit. The status word also carries the current byte count, so a handler knows how many data reads to issue.

Register map (2-bit word address): 0 = buffer data (read pops), 1 = interrupt enable, 2 = status, 3 = reads zero. Reads are registered: the read data appears on the cycle after the read strobe.

Top module: `ir_rx_fifo_irq`

## Requirements
- R1: After reset the buffer is empty, the status and enable words read 0, and irq_o is 0.
- R2: Up to 16 bytes are kept in arrival order. A read of address 0 returns the oldest byte in bits 7:0 and removes it.
- R3: A byte that arrives while 16 bytes are held, with no pop in the same cycle, is dropped. It sets the overflow flag (status bit 0).
- R4: A cycle with pkt_end_i high sets the packet-end flag (status bit 1).
- R5: The data-available flag (status bit 4) sets once the byte count exceeds the level field, which is enable bits 11:8. The field is programmed as the wanted count minus one.
- R6: Status bits 13:8 read the number of bytes currently held. All other status bits not named here read 0.
- R7: Writing to address 2 clears each of status bits 0, 1 and 4 that is written as one, and leaves the bits written as zero. If a flag's event occurs in the same cycle as its clear, the flag stays set.
- R8: irq_o is high exactly when some status bit 0, 1 or 4 is set together with the enable bit in the same position.
- R9: A read of address 0 while the buffer is empty returns 0 and leaves the count at 0.
- R10: The enable word (address 1) stores bits 0, 1, 4 and 11:8 and reads every other bit as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Encoder byte strobe |
| byte_i | input | 8 | Encoder run-length byte |
| pkt_end_i | input | 1 | Packet-end pulse from the encoder |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench runs the buffer with three fill patterns. A partial fill below the level shows the count field and an idle available flag. A fill just past a level of 7 shows the level-minus-one threshold. A 17-byte burst at a level of 15 shows the drop of the extra byte, the overflow flag and a count that saturates at 16. Each fill is drained against an in-order scoreboard, so a reordered, lost or duplicated byte shows up as a data mismatch. Clear writes with zero bits, with one bits, and in the same cycle as a packet-end pulse separate correct write-one-to-clear handling from a clear-all, a no-clear, or a clear that wins over a new event.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned NFLAG   = 3;
  localparam int unsigned LVL_LSB = 8;
  localparam int unsigned LVL_W   = 4;
  localparam int unsigned CNT_LSB = 8;
  localparam int unsigned CNT_FW  = 6;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 2'd0,
    A_IEN  = 2'd1,
    A_STA  = 2'd2,
    A_RSVD = 2'd3
  } reg_addr_e;

  // flag index: 0 overflow, 1 packet end, 2 data available
  function automatic int unsigned flag_pos(input int unsigned idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty, do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && (!full || do_pop);
  assign ovf_o   = push_i && full && !do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= din_i;
  end

  assign dout_o = empty ? '0 : mem_q[rd_ptr_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ir_rx_irq_ctrl.sv
module ir_rx_irq_ctrl import ir_rx_pkg::*; #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ovf_evt_i,
  input  logic             pkt_evt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic [NFLAG-1:0] en_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] set_v, flags_q;
  logic             avl_evt;

  if (CNT_W > LVL_W) begin : g_cmp_wide
    assign avl_evt = cnt_i > {{(CNT_W-LVL_W){1'b0}}, lvl_i};
  end else begin : g_cmp_narrow
    assign avl_evt = {{(LVL_W-CNT_W+1){1'b0}}, cnt_i} > {1'b0, lvl_i};
  end

  assign set_v = {avl_evt, pkt_evt_i, ovf_evt_i};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[i] <= 1'b0;
      else         flags_q[i] <= set_v[i] | (flags_q[i] & ~clr_i[i]);
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);
endmodule

// File: rtl/ir_rx_fifo_irq.sv
module ir_rx_fifo_irq import ir_rx_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              pkt_end_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  reg_addr_e         addr;
  logic              pop, wr_ien, wr_sta, ovf_evt;
  logic [DATA_W-1:0] fifo_dout;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [NFLAG-1:0]  en_q, sta_flags, clr_v, en_d;
  logic [LVL_W-1:0]  lvl_q;
  logic [REG_W-1:0]  ien_word, sta_word, rd_mux, rdata_q;
  logic              unused_wdata;

  assign addr   = reg_addr_e'(reg_addr_i);
  assign pop    = reg_rd_i && (addr == A_DATA);
  assign wr_ien = reg_wr_i && (addr == A_IEN);
  assign wr_sta = reg_wr_i && (addr == A_STA);

  for (genvar i = 0; i < NFLAG; i++) begin : g_bits
    assign en_d[i]  = reg_wdata_i[flag_pos(i)];
    assign clr_v[i] = wr_sta && reg_wdata_i[flag_pos(i)];
  end

  assign unused_wdata = ^{reg_wdata_i[REG_W-1:LVL_LSB+LVL_W], reg_wdata_i[7:5],
                          reg_wdata_i[3:2]};

  ir_rx_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (byte_valid_i),
    .din_i  (byte_i),
    .pop_i  (pop),
    .dout_o (fifo_dout),
    .cnt_o  (fifo_cnt),
    .ovf_o  (ovf_evt)
  );

  ir_rx_irq_ctrl #(.CNT_W(CNT_W)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovf_evt_i (ovf_evt),
    .pkt_evt_i (pkt_end_i),
    .cnt_i     (fifo_cnt),
    .lvl_i     (lvl_q),
    .clr_i     (clr_v),
    .en_i      (en_q),
    .flags_o   (sta_flags),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      lvl_q <= '0;
    end else if (wr_ien) begin
      en_q  <= en_d;
      lvl_q <= reg_wdata_i[LVL_LSB +: LVL_W];
    end
  end

  always_comb begin
    ien_word = '0;
    sta_word = '0;
    for (int i = 0; i < NFLAG; i++) begin
      ien_word[flag_pos(i)] = en_q[i];
      sta_word[flag_pos(i)] = sta_flags[i];
    end
    ien_word[LVL_LSB +: LVL_W] = lvl_q;
    sta_word[CNT_LSB +: CNT_FW] = CNT_FW'(fifo_cnt);
  end

  always_comb begin
    case (addr)
      A_DATA:  rd_mux = {{(REG_W-DATA_W){1'b0}}, fifo_dout};
      A_IEN:   rd_mux = ien_word;
      A_STA:   rd_mux = sta_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/ir_rx_fifo_irq_chk.sv
module ir_rx_fifo_irq_chk import ir_rx_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_valid_i,
  input logic              pkt_end_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [NFLAG-1:0]  flags_i
);
  logic rd_data;
  assign rd_data = reg_rd_i && (reg_addr_i == A_DATA);

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH));

  p_cnt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_valid_i && !rd_data) |=> $stable(cnt_i));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && cnt_i == CNT_W'(DEPTH) && !rd_data) |=>
      (flags_i[0] && cnt_i == CNT_W'(DEPTH)));

  p_pkt_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_i |=> flags_i[1]);

  p_pkt_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == A_STA && reg_wdata_i[1] && !pkt_end_i) |=> !flags_i[1]);

  p_empty_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && cnt_i == '0 && !byte_valid_i) |=> (reg_rdata_o == '0 && cnt_i == '0));
endmodule

bind ir_rx_fifo_irq ir_rx_fifo_irq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_valid_i (byte_valid_i),
  .pkt_end_i    (pkt_end_i),
  .reg_wr_i     (reg_wr_i),
  .reg_rd_i     (reg_rd_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .cnt_i        (fifo_cnt),
  .flags_i      (sta_flags)
);

// File: tb/ir_rx_fifo_irq_bench.sv
module ir_rx_fifo_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        pkt_end_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_q[$];
  bit   pend_pop = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ir_rx_fifo_irq u_ir_rx_fifo_irq (
    .clk_i, .rst_ni, .byte_valid_i, .byte_i, .pkt_end_i,
    .reg_wr_i, .reg_rd_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic push(input logic [7:0] b);
    byte_valid_i = 1'b1; byte_i = b;
    if (exp_q.size() < 16) exp_q.push_back(b);
    @(negedge clk_i);
    byte_valid_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_rd_i = 1'b1; reg_addr_i = a;
    @(negedge clk_i);
    d = reg_rdata_o;
    reg_rd_i = 1'b0;
  endtask

  // monitor: scoreboard pop on every data read
  always @(posedge clk_i) if (reg_rd_i && reg_addr_i == 2'd0) pend_pop = 1;
  always @(negedge clk_i) begin
    if (pend_pop) begin
      pend_pop = 0;
      if (exp_q.size() == 0) check("R9 empty read", reg_rdata_o, 32'h0);
      else check("R2 data order", reg_rdata_o, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic drain(input int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) rd(2'd0, d);
    idle(1);
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    rd(2'd2, d); check("R1 status", d, 32'h0);
    rd(2'd1, d); check("R1 enable", d, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);

    // R10 enable readback mask
    wr(2'd1, 32'hA5A5_F7F3);
    rd(2'd1, d); check("R10 enable mask", d, 32'h0000_0713);
    rd(2'd3, d); check("R10 reserved addr", d, 32'h0);
    wr(2'd1, 32'h0000_0700);

    // R5/R6 partial fill below level 7
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    idle(1);
    rd(2'd2, d); check("R6 count 5", d, 32'h0000_0500);
    for (int i = 0; i < 3; i++) push(8'h80 + 8'(i));
    idle(1);
    rd(2'd2, d); check("R5 avail at 8", d, 32'h0000_0810);
    check("R8 irq masked", {31'h0, irq_o}, 32'h0);
    wr(2'd1, 32'h0000_0710);
    check("R8 irq enabled", {31'h0, irq_o}, 32'h1);
    drain(8);
    rd(2'd2, d); check("R6 count drained", d, 32'h0000_0010);
    wr(2'd2, 32'h0000_00EF);
    rd(2'd2, d); check("R7 zero bit keeps flag", d, 32'h0000_0010);
    wr(2'd2, 32'h0000_0010);
    rd(2'd2, d); check("R7 clear avail", d, 32'h0);
    check("R8 irq low after clear", {31'h0, irq_o}, 32'h0);

    // R9 empty read
    drain(1);
    rd(2'd2, d); check("R9 count stays 0", d, 32'h0);

    // R3 overflow with level 15
    wr(2'd1, 32'h0000_0F01);
    for (int i = 0; i < 17; i++) push(8'(8'h3 * i + 8'h41));
    idle(1);
    rd(2'd2, d); check("R3 overflow and full count", d, 32'h0000_1011);
    check("R8 irq on overflow", {31'h0, irq_o}, 32'h1);
    drain(16);
    wr(2'd2, 32'h0000_00FF);
    rd(2'd2, d); check("R7 clear all", d, 32'h0);
    check("R8 irq low", {31'h0, irq_o}, 32'h0);

    // R4 packet end, and event winning over clear
    wr(2'd1, 32'h0000_0F02);
    pkt_end_i = 1'b1; idle(1); pkt_end_i = 1'b0;
    rd(2'd2, d); check("R4 packet end flag", d, 32'h0000_0002);
    check("R8 irq on packet end", {31'h0, irq_o}, 32'h1);
    pkt_end_i = 1'b1;
    wr(2'd2, 32'h0000_0002);
    pkt_end_i = 1'b0;
    rd(2'd2, d); check("R7 set wins over clear", d, 32'h0000_0002);
    wr(2'd2, 32'h0000_0002);
    rd(2'd2, d); check("R7 clear packet end", d, 32'h0);

    done = 1;
    report();
  end
endmodule